// File: doc/BRIEF.md
# Buffer Ownership Semaphore Arbiter

This block settles which side may touch a pair of shared transfer buffers: the local processor or a serial slave engine that is driven by an external master. The processor issues single-cycle take and give-back requests. The serial side reports when its chip select becomes active and when it becomes inactive. The arbiter keeps a four-state ownership code and tells the serial engine whether the transaction in progress may use the buffers. If it may not, the engine is told to send filler characters.

Two one-cycle events report ownership changes: one fires when the processor gains the buffers, and one fires when a transaction granted to the serial side finishes. Each event also latches a sticky pending flag, which software clears. A per-event interrupt enable, set and cleared through separate ports, gates the flags onto one interrupt line. An optional shortcut issues a take request on the processor's behalf each time a granted transaction finishes, so the buffers return to the processor without software having to act.

Top module: `buf_own_arbiter`

## Requirements
- R1: After reset the status code is 0, grant, filler, both event pulses, both pending flags, both interrupt enables and the interrupt line are all 0.
- R2: Status codes: 0 free, 1 processor owns, 2 serial side owns, 3 serial side owns with a handover to the processor pending. A take request while free gives status 1 at the next clock edge, and the acquired pulse is high for exactly that one cycle.
- R3: A give-back request while the status is 1 returns it to 0 at the next edge. A give-back request while the status is 2 or 3 is ignored, and so is a take request while the status is 1.
- R4: A chip-select start while free gives status 2 with grant high and filler low. The matching chip-select end gives status 0, grant low and a one-cycle end pulse.
- R5: A take request while the status is 2 gives status 3. Grant stays high and no acquired pulse is raised. When that transaction ends, status becomes 1 and the end and acquired pulses are high in the same cycle.
- R6: A chip-select start while the status is 1 opens an ungranted transaction: grant stays low, filler goes high, the status does not change, and its end raises no end pulse.
- R7: After a give-back, the serial side takes ownership only at its next chip-select start. A transaction that is already in progress, ungranted, stays ungranted, and its end raises no end pulse.
- R8: With the shortcut enabled, an end pulse acts as a take request. The status is 0 in the end-pulse cycle and becomes 1, with an acquired pulse, one cycle later.
- R9: A take request and a chip-select start in the same cycle while free: the processor wins (status 1, acquired pulse), and the transaction is ungranted.
- R10: Pending flags: bit 0 is the end event and bit 1 is the acquired event. A flag is set one cycle after its pulse and holds until its clear bit is written. A set arriving in the same cycle as a clear wins.
- R11: Interrupt enables (bit 0 end, bit 1 acquired) are set and cleared by separate ports, and a set beats a clear in the same cycle. The interrupt line is high exactly when some pending flag has its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acquire_i | input | 1 | Processor take request pulse |
| release_i | input | 1 | Processor give-back pulse |
| cs_on_i | input | 1 | Chip select became active |
| cs_off_i | input | 1 | Chip select became inactive |
| short_en_i | input | 1 | End-to-take shortcut enable |
| evt_clr_i | input | 2 | Clear pending flags (bit 0 end, bit 1 acquired) |
| irq_en_set_i | input | 2 | Set interrupt enables |
| irq_en_clr_i | input | 2 | Clear interrupt enables |
| status_o | output | 2 | Ownership code |
| grant_o | output | 1 | Serial transaction may use the buffers |
| dflt_o | output | 1 | Ungranted transaction active: send filler |
| end_o | output | 1 | Granted transaction finished (one cycle) |
| acquired_o | output | 1 | Processor gained ownership (one cycle) |
| evt_pend_o | output | 2 | Sticky pending event flags |
| irq_en_o | output | 2 | Interrupt enables |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets the handover from status 3. A design that hands over early would drop grant in the middle of a transfer, and one that forgets the pending take would leave the buffers free rather than owned by the processor. It checks that an ungranted transaction never raises an end pulse, including one left running across a give-back. A design that grants on the state alone would hand the buffers over in the middle of a frame. It also covers the same-cycle take-plus-start tie, the one-cycle gap created by the shortcut, and set-beats-clear on flags and enables, where a wrong priority silently loses events.

// File: rtl/bos_pkg.sv
package bos_pkg;

  typedef enum logic [1:0] {
    SEM_FREE = 2'd0,
    SEM_CPU  = 2'd1,
    SEM_SLV  = 2'd2,
    SEM_PEND = 2'd3
  } sem_e;

  localparam int unsigned EVT_NUM = 2;
  localparam int unsigned EVT_END = 0;
  localparam int unsigned EVT_ACQ = 1;

  typedef struct packed {
    sem_e nxt;
    logic end_evt;
    logic acq_evt;
  } sem_step_t;

  // Next ownership state and the events raised by that transition.
  function automatic sem_step_t sem_next(input sem_e cur, input logic acq,
                                         input logic rel, input logic start,
                                         input logic fin);
    sem_step_t s;
    s.nxt     = cur;
    s.end_evt = 1'b0;
    s.acq_evt = 1'b0;
    unique case (cur)
      SEM_FREE: begin
        if (acq) begin
          s.nxt     = SEM_CPU;
          s.acq_evt = 1'b1;
        end else if (start) begin
          s.nxt = SEM_SLV;
        end
      end
      SEM_CPU: begin
        if (rel) s.nxt = SEM_FREE;
      end
      SEM_SLV: begin
        if (fin) begin
          s.end_evt = 1'b1;
          if (acq) begin
            s.nxt     = SEM_CPU;
            s.acq_evt = 1'b1;
          end else begin
            s.nxt = SEM_FREE;
          end
        end else if (acq) begin
          s.nxt = SEM_PEND;
        end
      end
      SEM_PEND: begin
        if (fin) begin
          s.nxt     = SEM_CPU;
          s.end_evt = 1'b1;
          s.acq_evt = 1'b1;
        end
      end
      default: s.nxt = SEM_FREE;
    endcase
    return s;
  endfunction

  // Sticky bit update: a set beats a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/bos_xfer.sv
module bos_xfer (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_on_i,
  input  logic cs_off_i,
  output logic active_o,
  output logic start_o,
  output logic fin_o
);

  logic active_q;

  // A start only counts while idle, an end only while active.
  assign start_o = cs_on_i & ~active_q;
  assign fin_o   = cs_off_i & active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (start_o) begin
      active_q <= 1'b1;
    end else if (fin_o) begin
      active_q <= 1'b0;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/bos_sem_fsm.sv
module bos_sem_fsm
  import bos_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acq_i,
  input  logic rel_i,
  input  logic start_i,
  input  logic fin_i,
  output sem_e state_o,
  output logic end_o,
  output logic acq_evt_o
);

  sem_e      state_q;
  logic      end_q;
  logic      acq_q;
  sem_step_t step;

  always_comb begin
    step = sem_next(state_q, acq_i, rel_i, start_i, fin_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEM_FREE;
      end_q   <= 1'b0;
      acq_q   <= 1'b0;
    end else begin
      state_q <= step.nxt;
      end_q   <= step.end_evt;
      acq_q   <= step.acq_evt;
    end
  end

  assign state_o   = state_q;
  assign end_o     = end_q;
  assign acq_evt_o = acq_q;

endmodule

// File: rtl/bos_evt_irq.sv
module bos_evt_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_set_i,
  input  logic [N-1:0] en_clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  import bos_pkg::*;

  logic [N-1:0] pend_q;
  logic [N-1:0] en_q;

  for (genvar g = 0; g < N; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        en_q[g]   <= 1'b0;
      end else begin
        pend_q[g] <= sticky_next(pend_q[g], evt_i[g], clr_i[g]);
        en_q[g]   <= sticky_next(en_q[g], en_set_i[g], en_clr_i[g]);
      end
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);

endmodule

// File: rtl/buf_own_arbiter.sv
module buf_own_arbiter
  import bos_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acquire_i,
  input  logic               release_i,
  input  logic               cs_on_i,
  input  logic               cs_off_i,
  input  logic               short_en_i,
  input  logic [EVT_NUM-1:0] evt_clr_i,
  input  logic [EVT_NUM-1:0] irq_en_set_i,
  input  logic [EVT_NUM-1:0] irq_en_clr_i,
  output logic [1:0]         status_o,
  output logic               grant_o,
  output logic               dflt_o,
  output logic               end_o,
  output logic               acquired_o,
  output logic [EVT_NUM-1:0] evt_pend_o,
  output logic [EVT_NUM-1:0] irq_en_o,
  output logic               irq_o
);

  logic         xfer_active;
  logic         xfer_start;
  logic         xfer_fin;
  logic         acq_eff;
  logic         end_pulse;
  logic         acq_pulse;
  sem_e         sem_state;
  logic [EVT_NUM-1:0] evt_vec;

  bos_xfer i_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_on_i  (cs_on_i),
    .cs_off_i (cs_off_i),
    .active_o (xfer_active),
    .start_o  (xfer_start),
    .fin_o    (xfer_fin)
  );

  // Shortcut: a finished granted transaction re-issues a take request.
  assign acq_eff = acquire_i | (end_pulse & short_en_i);

  bos_sem_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_i     (acq_eff),
    .rel_i     (release_i),
    .start_i   (xfer_start),
    .fin_i     (xfer_fin),
    .state_o   (sem_state),
    .end_o     (end_pulse),
    .acq_evt_o (acq_pulse)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[EVT_END] = end_pulse;
    evt_vec[EVT_ACQ] = acq_pulse;
  end

  bos_evt_irq #(.N(EVT_NUM)) i_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_vec),
    .clr_i    (evt_clr_i),
    .en_set_i (irq_en_set_i),
    .en_clr_i (irq_en_clr_i),
    .pend_o   (evt_pend_o),
    .en_o     (irq_en_o),
    .irq_o    (irq_o)
  );

  assign status_o   = sem_state;
  assign grant_o    = (sem_state == SEM_SLV) || (sem_state == SEM_PEND);
  assign dflt_o     = xfer_active & ~grant_o;
  assign end_o      = end_pulse;
  assign acquired_o = acq_pulse;

endmodule

// File: rtl/bos_chk.sv
module bos_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] status_o,
  input logic       grant_o,
  input logic       end_o,
  input logic       acquired_o,
  input logic       release_i,
  input logic [1:0] evt_pend_o
);

  // R2: the acquired pulse only ever comes with processor ownership
  p_acq_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acquired_o |-> (status_o == 2'd1));

  // R3: leaving processor ownership for free needs a give-back
  p_release_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) == 2'd1 && status_o == 2'd0) |-> $past(release_i));

  // R4: an end pulse only follows a granted transaction
  p_end_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> $past(grant_o));

  // R5: the pending state is reached only from serial ownership
  p_pend_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'd3) |-> ($past(status_o) == 2'd2 || $past(status_o) == 2'd3));

  // R7: grant starts only from the free state
  p_grant_from_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> ($past(status_o) == 2'd0));

  // R10: the acquired flag rises only after an acquired pulse
  p_flag_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_pend_o[1]) |-> $past(acquired_o));

endmodule

bind buf_own_arbiter bos_chk i_bos_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status_o   (status_o),
  .grant_o    (grant_o),
  .end_o      (end_o),
  .acquired_o (acquired_o),
  .release_i  (release_i),
  .evt_pend_o (evt_pend_o)
);

// File: tb/test_buf_own_arbiter.sv
module test_buf_own_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acquire_i = 1'b0, release_i = 1'b0, cs_on_i = 1'b0, cs_off_i = 1'b0;
  logic       short_en_i = 1'b0;
  logic [1:0] evt_clr_i = '0, irq_en_set_i = '0, irq_en_clr_i = '0;
  logic [1:0] status_o, evt_pend_o, irq_en_o;
  logic       grant_o, dflt_o, end_o, acquired_o, irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  buf_own_arbiter i_buf_own_arbiter (
    .clk(clk), .rst_n(rst_n), .acquire_i(acquire_i), .release_i(release_i),
    .cs_on_i(cs_on_i), .cs_off_i(cs_off_i), .short_en_i(short_en_i),
    .evt_clr_i(evt_clr_i), .irq_en_set_i(irq_en_set_i), .irq_en_clr_i(irq_en_clr_i),
    .status_o(status_o), .grant_o(grant_o), .dflt_o(dflt_o), .end_o(end_o),
    .acquired_o(acquired_o), .evt_pend_o(evt_pend_o), .irq_en_o(irq_en_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock edge; pulse inputs drop at the following falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    acquire_i = 0; release_i = 0; cs_on_i = 0; cs_off_i = 0;
    evt_clr_i = '0; irq_en_set_i = '0; irq_en_clr_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    short_en_i = 0;
    tick();
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", status_o, 0);
    chk("R1 grant", grant_o, 0);
    chk("R1 dflt", dflt_o, 0);
    chk("R1 end", end_o, 0);
    chk("R1 acquired", acquired_o, 0);
    chk("R1 pend", evt_pend_o, 0);
    chk("R1 irq_en", irq_en_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_acquire();
    do_reset();
    acquire_i = 1; tick();
    chk("R2 status cpu", status_o, 1);
    chk("R2 acquired pulse", acquired_o, 1);
    tick();
    chk("R2 pulse one cycle", acquired_o, 0);
    chk("R10 acq flag set", evt_pend_o, 2'b10);
    acquire_i = 1; tick();
    chk("R3 acquire in cpu ignored status", status_o, 1);
    chk("R3 acquire in cpu no pulse", acquired_o, 0);
    release_i = 1; tick();
    chk("R3 release frees", status_o, 0);
    evt_clr_i = 2'b10; tick();
    chk("R10 flag cleared", evt_pend_o, 0);
    acquire_i = 1; tick();
    chk("R2 reacquire", acquired_o, 1);
    evt_clr_i = 2'b10; tick();
    chk("R10 set beats clear", evt_pend_o, 2'b10);
  endtask

  task automatic t_slave();
    do_reset();
    cs_on_i = 1; tick();
    chk("R4 status slave", status_o, 2);
    chk("R4 grant", grant_o, 1);
    chk("R4 no filler", dflt_o, 0);
    release_i = 1; tick();
    chk("R3 release in slave ignored", status_o, 2);
    cs_off_i = 1; tick();
    chk("R4 end pulse", end_o, 1);
    chk("R4 status free", status_o, 0);
    chk("R4 grant drops", grant_o, 0);
    tick();
    chk("R4 end one cycle", end_o, 0);
    chk("R10 end flag", evt_pend_o, 2'b01);
    chk("R8 no shortcut stays free", status_o, 0);
  endtask

  task automatic t_pending();
    do_reset();
    cs_on_i = 1; tick();
    acquire_i = 1; tick();
    chk("R5 status pend", status_o, 3);
    chk("R5 grant held", grant_o, 1);
    chk("R5 no acquired yet", acquired_o, 0);
    tick();
    chk("R5 pend holds", status_o, 3);
    cs_off_i = 1; tick();
    chk("R5 handover status", status_o, 1);
    chk("R5 end pulse", end_o, 1);
    chk("R5 acquired pulse", acquired_o, 1);
    chk("R5 grant off", grant_o, 0);
  endtask

  task automatic t_ungranted();
    do_reset();
    acquire_i = 1; tick();
    cs_on_i = 1; tick();
    chk("R6 status kept", status_o, 1);
    chk("R6 no grant", grant_o, 0);
    chk("R6 filler", dflt_o, 1);
    cs_off_i = 1; tick();
    chk("R6 no end", end_o, 0);
    chk("R6 filler off", dflt_o, 0);
    tick();
    chk("R6 no end flag", evt_pend_o, 2'b10);
    cs_on_i = 1; tick();
    release_i = 1; tick();
    chk("R7 freed mid transfer", status_o, 0);
    chk("R7 still ungranted", grant_o, 0);
    chk("R7 still filler", dflt_o, 1);
    cs_off_i = 1; tick();
    chk("R7 no end", end_o, 0);
    chk("R7 free", status_o, 0);
    cs_on_i = 1; tick();
    chk("R7 slave takes", status_o, 2);
    chk("R7 grant", grant_o, 1);
  endtask

  task automatic t_shortcut();
    do_reset();
    short_en_i = 1;
    cs_on_i = 1; tick();
    cs_off_i = 1; tick();
    chk("R8 end pulse", end_o, 1);
    chk("R8 free gap", status_o, 0);
    chk("R8 no acquired yet", acquired_o, 0);
    tick();
    chk("R8 cpu owns", status_o, 1);
    chk("R8 acquired", acquired_o, 1);
    short_en_i = 0;
  endtask

  task automatic t_tie();
    do_reset();
    acquire_i = 1; cs_on_i = 1; tick();
    chk("R9 cpu wins", status_o, 1);
    chk("R9 acquired", acquired_o, 1);
    chk("R9 no grant", grant_o, 0);
    chk("R9 filler", dflt_o, 1);
  endtask

  task automatic t_irq();
    do_reset();
    cs_on_i = 1; tick();
    cs_off_i = 1; tick();
    acquire_i = 1; tick();
    tick();
    chk("R10 both flags", evt_pend_o, 2'b11);
    chk("R11 irq masked", irq_o, 0);
    irq_en_set_i = 2'b01; tick();
    chk("R11 en end", irq_en_o, 2'b01);
    chk("R11 irq on", irq_o, 1);
    evt_clr_i = 2'b01; tick();
    chk("R10 end cleared", evt_pend_o, 2'b10);
    chk("R11 irq off", irq_o, 0);
    irq_en_set_i = 2'b10; tick();
    chk("R11 irq acq", irq_o, 1);
    irq_en_set_i = 2'b10; irq_en_clr_i = 2'b10; tick();
    chk("R11 set beats clear", irq_en_o, 2'b11);
    irq_en_clr_i = 2'b11; tick();
    chk("R11 cleared", irq_en_o, 0);
    chk("R11 irq low", irq_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_acquire();
    t_slave();
    t_pending();
    t_ungranted();
    t_shortcut();
    t_tie();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule